// File: doc/BRIEF.md
# Regulator Startup Delay Sequencer

This block produces the regulator-ready signal that lets the reset manager release the device reset. It runs in two situations: the first power-up, and each return from a low-power mode. At power-up, a settling counter is held cleared until the ultra-low-power domain reports that it is powered. On a low-power exit, the same counter is held cleared while the high-power regulator power-down request is present, and it starts counting when that request is removed. When the count completes, an end-of-count condition is raised. The ready output is that condition ANDed with the main-domain voltage-good flag.

The block also forwards the status bits of the low-voltage detectors. A detector that is powered down reads as healthy. A single-bit mask register, written through a plain write strobe, forces the 5 V detector's status to the healthy value. This keeps startup glitches of that detector from reaching the rest of the chip. Every asynchronous flag passes through a two-flop synchronizer before any logic uses it.

Top module: `regseq_top`

## Requirements
- R1: While reset is held and just after it is released, `reg_ok_o` is 0 and the mask bit is 1. With the mask at 1, `lvd_stat_o[HV_IDX]` reads 1, where 1 means healthy and `HV_IDX` defaults to 2.
- R2: While `ulp_pwr_ok_i` is 0, `reg_ok_o` stays 0 however long that lasts. Suppose `ulp_pwr_ok_i` rises with `vdd_main_ok_i`=1 and `hpreg_pd_req_i`=0. Then `reg_ok_o` is still 0 after DELAY+1 rising clock edges and is 1 after DELAY+2 edges. DELAY defaults to 256.
- R3: `reg_ok_o` is the completed count ANDed with the synchronized `vdd_main_ok_i`. A change of `vdd_main_ok_i` appears on `reg_ok_o` exactly 2 edges later, and restoring the flag does not restart the delay.
- R4: Raising `hpreg_pd_req_i` drives `reg_ok_o` to 0 exactly 2 edges later. It stays 0 for as long as the request is held.
- R5: Removing `hpreg_pd_req_i` restarts the full delay: `reg_ok_o` is 0 after DELAY+1 edges and 1 after DELAY+2 edges.
- R6: Once the count completes, the counter stays at its terminal value, so `reg_ok_o` remains 1 indefinitely while its inputs are unchanged.
- R7: `mask_we_i` loads `mask_wdata_i` into the mask bit on the next edge. With the mask at 0, `lvd_stat_o[HV_IDX]` follows `lvd_stat_i[HV_IDX]` with a 2-edge latency. With the mask at 1, it reads 1.
- R8: When `lvd_pd_i[i]` is 1, `lvd_stat_o[i]` reads 1 two edges later, whatever the value of `lvd_stat_i[i]`.
- R9: `ulp_pwr_ok_i` falling clears the count. `reg_ok_o` drops 2 edges later, and the next rise of `ulp_pwr_ok_i` restarts the full delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ulp_pwr_ok_i | input | 1 | Ultra-low-power domain powered (async) |
| hpreg_pd_req_i | input | 1 | High-power regulator power-down request (async) |
| vdd_main_ok_i | input | 1 | Main-domain voltage good (async) |
| lvd_stat_i | input | N_LVD | Detector status, 1 = healthy (async) |
| lvd_pd_i | input | N_LVD | Detector power-down controls (async) |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_wdata_i | input | 1 | Mask value to write |
| reg_ok_o | output | 1 | Regulator ready, releases device reset |
| lvd_stat_o | output | N_LVD | Masked and forwarded detector status |

## Verification
Each flag input reaches the outputs after exactly two rising edges, which is the depth of the synchronizer. The one exception is `reg_ok_o` after a clear is lifted: it rises DELAY+2 edges after the stimulus. A mask write takes effect one edge after the strobe. The bench drives every stimulus on a falling edge, counts the rising edges it has waited, and samples 1 ns after a rising edge. For each timed result it checks both the last cycle before the expected change and the cycle of the change, so a single-cycle shift in latency is reported.

// File: rtl/regseq_pkg.sv
package regseq_pkg;
  typedef struct packed {
    logic vdd_ok;
    logic hp_pd_req;
    logic ulp_ok;
  } ctl_flags_t;

  localparam int CTL_W = $bits(ctl_flags_t);
endpackage

// File: rtl/regseq_sync.sv
module regseq_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/regseq_delay.sv
module regseq_delay #(
  parameter int DELAY = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic eoc_o
);
  localparam int          CW   = $clog2(DELAY + 1);
  localparam logic [CW-1:0] TERM = CW'(DELAY);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clr_i)          cnt_q <= '0;
    else if (cnt_q != TERM)  cnt_q <= cnt_q + 1'b1;
  end

  // clear takes end-of-count down in the same cycle
  assign eoc_o = (cnt_q == TERM) && !clr_i;

  a_r2_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= TERM);
  a_r6_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == TERM && !clr_i) |=> (cnt_q == TERM));
  a_r2_eoc_after_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(eoc_o) |-> ($past(cnt_q) == TERM - 1));
endmodule

// File: rtl/regseq_lvd.sv
module regseq_lvd #(
  parameter int N_LVD  = 3,
  parameter int HV_IDX = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_LVD-1:0] stat_i,
  input  logic [N_LVD-1:0] pd_i,
  input  logic             mask_we_i,
  input  logic             mask_wdata_i,
  output logic [N_LVD-1:0] stat_o
);
  logic mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= 1'b1;
    else if (mask_we_i) mask_q <= mask_wdata_i;
  end

  for (genvar i = 0; i < N_LVD; i++) begin : g_lvd
    if (i == HV_IDX) begin : g_hv
      assign stat_o[i] = pd_i[i] | mask_q | stat_i[i];
    end else begin : g_lv
      assign stat_o[i] = pd_i[i] | stat_i[i];
    end
  end

  a_r7_mask_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_we_i |=> (mask_q == $past(mask_wdata_i)));
  a_r7_mask_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_we_i |=> $stable(mask_q));
endmodule

// File: rtl/regseq_top.sv
module regseq_top
  import regseq_pkg::*;
#(
  parameter int DELAY  = 256,
  parameter int N_LVD  = 3,
  parameter int HV_IDX = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ulp_pwr_ok_i,
  input  logic             hpreg_pd_req_i,
  input  logic             vdd_main_ok_i,
  input  logic [N_LVD-1:0] lvd_stat_i,
  input  logic [N_LVD-1:0] lvd_pd_i,
  input  logic             mask_we_i,
  input  logic             mask_wdata_i,
  output logic             reg_ok_o,
  output logic [N_LVD-1:0] lvd_stat_o
);
  localparam int SW = CTL_W + 2 * N_LVD;
  localparam logic [SW-1:0] SYNC_RST = {{N_LVD{1'b0}}, {N_LVD{1'b1}}, {CTL_W{1'b0}}};

  ctl_flags_t       flags_s;
  logic [N_LVD-1:0] stat_s, pd_s;
  logic             eoc;
  logic             cnt_clr;

  regseq_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({lvd_pd_i, lvd_stat_i, vdd_main_ok_i, hpreg_pd_req_i, ulp_pwr_ok_i}),
    .q_o    ({pd_s, stat_s, flags_s})
  );

  assign cnt_clr = !flags_s.ulp_ok || flags_s.hp_pd_req;

  regseq_delay #(.DELAY(DELAY)) u_delay (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .eoc_o  (eoc)
  );

  assign reg_ok_o = eoc && flags_s.vdd_ok;

  regseq_lvd #(.N_LVD(N_LVD), .HV_IDX(HV_IDX)) u_lvd (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .stat_i       (stat_s),
    .pd_i         (pd_s),
    .mask_we_i    (mask_we_i),
    .mask_wdata_i (mask_wdata_i),
    .stat_o       (lvd_stat_o)
  );

  a_r3_ok_needs_vdd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_ok_o |-> flags_s.vdd_ok);
  a_r4_pd_blocks_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_s.hp_pd_req |-> !reg_ok_o);
  a_r9_ulp_blocks_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flags_s.ulp_ok |-> !reg_ok_o);
  a_r8_pd_reads_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pd_s == {N_LVD{1'b1}}) |-> (lvd_stat_o == {N_LVD{1'b1}}));
endmodule

// File: tb/sim_regseq_top.sv
`timescale 1ns/1ps
module sim_regseq_top;
  localparam int D  = 256;
  localparam int N  = 3;
  localparam int HV = 2;

  logic clk = 0, rst_n = 0;
  logic ulp = 0, pd = 0, vdd = 0, we = 0, wd = 0;
  logic [N-1:0] stat = '0, lpd = '0;
  logic reg_ok;
  logic [N-1:0] stat_o;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  regseq_top #(.DELAY(D), .N_LVD(N), .HV_IDX(HV)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ulp_pwr_ok_i(ulp), .hpreg_pd_req_i(pd),
    .vdd_main_ok_i(vdd), .lvd_stat_i(stat), .lvd_pd_i(lpd),
    .mask_we_i(we), .mask_wdata_i(wd), .reg_ok_o(reg_ok), .lvd_stat_o(stat_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    #1; chk("R1 ok in reset", reg_ok, 0);
    chk("R1 hv masked in reset", stat_o[HV], 1);
    @(negedge clk); rst_n = 1;
    edges(4);
    chk("R1 ok after reset", reg_ok, 0);
    chk("R1 masked status", stat_o, 3'b100);
    vdd = 1;
    edges(2 * D);
    chk("R2 held while ulp low", reg_ok, 0);
  endtask

  task automatic t_startup;
    @(negedge clk); ulp = 1;
    edges(D + 1); chk("R2 not yet ok", reg_ok, 0);
    edges(1);     chk("R2 ok at delay", reg_ok, 1);
  endtask

  task automatic t_saturate;
    edges(4 * D);
    chk("R6 ok stays", reg_ok, 1);
  endtask

  task automatic t_vdd;
    @(negedge clk); vdd = 0;
    edges(1); chk("R3 vdd drop latency", reg_ok, 1);
    edges(1); chk("R3 vdd drop", reg_ok, 0);
    @(negedge clk); vdd = 1;
    edges(1); chk("R3 vdd back latency", reg_ok, 0);
    edges(1); chk("R3 vdd back no delay", reg_ok, 1);
  endtask

  task automatic t_pd;
    @(negedge clk); pd = 1;
    edges(1); chk("R4 pd latency", reg_ok, 1);
    edges(1); chk("R4 pd drop", reg_ok, 0);
    edges(2 * D); chk("R4 pd hold", reg_ok, 0);
    @(negedge clk); pd = 0;
    edges(D + 1); chk("R5 not yet ok", reg_ok, 0);
    edges(1);     chk("R5 ok after exit", reg_ok, 1);
  endtask

  task automatic t_ulp_drop;
    @(negedge clk); ulp = 0;
    edges(1); chk("R9 ulp latency", reg_ok, 1);
    edges(1); chk("R9 ulp drop", reg_ok, 0);
    @(negedge clk); ulp = 1;
    edges(D + 1); chk("R9 not yet ok", reg_ok, 0);
    edges(1);     chk("R9 ok again", reg_ok, 1);
  endtask

  task automatic t_mask;
    chk("R7 masked with fault", stat_o, 3'b100);
    @(negedge clk); we = 1; wd = 0;
    @(negedge clk); we = 0;
    #0; chk("R7 unmasked", stat_o, 3'b000);
    @(negedge clk); stat = 3'b111;
    edges(1); chk("R7 pass latency", stat_o, 3'b000);
    edges(1); chk("R7 pass through", stat_o, 3'b111);
    @(negedge clk); stat = 3'b000;
    edges(2); chk("R7 fault seen", stat_o, 3'b000);
    @(negedge clk); we = 1; wd = 1;
    @(negedge clk); we = 0;
    chk("R7 remasked", stat_o, 3'b100);
    @(negedge clk); we = 1; wd = 0;
    @(negedge clk); we = 0;
  endtask

  task automatic t_lvd_pd;
    @(negedge clk); lpd = 3'b011;
    edges(1); chk("R8 pd latency", stat_o, 3'b000);
    edges(1); chk("R8 pd reads healthy", stat_o, 3'b011);
    @(negedge clk); lpd = 3'b100;
    edges(2); chk("R8 hv pd reads healthy", stat_o, 3'b100);
    @(negedge clk); lpd = 3'b000;
    edges(2); chk("R8 pd released", stat_o, 3'b000);
  endtask

  initial begin
    fork
      begin
        edges(3);
        t_reset;
        t_startup;
        t_saturate;
        t_vdd;
        t_pd;
        t_ulp_drop;
        t_mask;
        t_lvd_pd;
      end
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule